// File: doc/BRIEF.md
# ADC Gain Split Controller

The block turns one 8-bit combined gain code per stereo channel into two parts: a 7-bit setting for the analog input amplifier that sits in front of the converter, and a digital attenuation applied to the converted 24-bit samples. Codes above the crossover code 0xA5 raise the analog gain in 0.5 dB steps, with the digital stage at unity. Codes at or below the crossover hold the amplifier at its lowest setting (−21 dB) and attenuate digitally in 0.5 dB steps. Code 0x00 mutes the channel.

A per-channel enable can hold each amplifier change until the converted signal of that channel changes sign, so that gain steps land near a zero crossing. A timeout forces the change if no crossing arrives. When a code change moves the amplifier setting, the new digital attenuation is applied on the same sample as the new amplifier setting. The total gain therefore never steps in two stages. A change that leaves the amplifier setting alone reaches the digital stage at once.

Top module: `adc_gain_split`

## Requirements
- R1: `pga_code_o` of a channel is `code − 0xA5` for committed codes 0xA5..0xFF (0xCF gives 42, 0xFF gives 90) and 0 for codes 0x00..0xA5.
- R2: For codes 0x01..0xFF, with n = 0xA5 − code (0 for codes above 0xA5), the output sample is floor(sample × C[n mod 12] / 2^(16 + n div 12)), where C[r] = round(65536 × 10^(−r/40)).
- R3: Code 0x00 gives an output sample of 0.
- R4: With the channel's zero-cross enable low, `pga_code_o` follows a new code at the first clock edge after the code is applied.
- R5: With the enable high, a pending amplifier change is held. It commits on a valid sample whose bit 23 differs from bit 23 of the previous valid sample of that channel. After reset, the previous sign counts as positive.
- R6: With the enable high and no crossing, the pending change commits on the 4096th valid sample after it became pending.
- R7: When a pending change alters the amplifier setting, samples keep the digital attenuation of the committed code until the commit sample. The commit sample gets the new code's attenuation and the new `pga_code_o` at the same edge.
- R8: A code change that leaves the amplifier setting unchanged affects the digital attenuation of the next valid sample, even while a zero-crossing wait is in progress.
- R9: `sample_o` and `valid_o` are registered one cycle after `valid_i`. Without `valid_i`, `valid_o` is low and `sample_o` holds.
- R10: During reset, `pga_code_o`, `sample_o` and `valid_o` are all 0.
- R11: The channels are independent: codes, enables and samples of one channel do not affect the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gain_code_i | input | NUM_CH×8 | Combined gain code per channel |
| zc_en_i | input | NUM_CH | Zero-cross timing enable per channel |
| sample_i | input | NUM_CH×SW | Converted signed samples |
| valid_i | input | 1 | Sample strobe, common to all channels |
| pga_code_o | output | NUM_CH×7 | Amplifier index, 0 = −21 dB, 90 = +24 dB |
| sample_o | output | NUM_CH×SW | Digitally attenuated samples |
| valid_o | output | 1 | Output sample strobe |

## Verification
Both results are due one clock edge after the inputs are presented. The attenuated sample and `valid_o` come from the edge that sees `valid_i`, and an amplifier commit appears at that same edge. The bench drives inputs after a falling edge, waits for one rising edge and samples at the next falling edge, so each check sees exactly the result of one edge. The timeout case counts 4095 held samples before checking the edge at which the commit is due.

// File: rtl/adc_gain_pkg.sv
package adc_gain_pkg;
  localparam int CODE_W = 8;
  localparam int PGA_W  = 7;
  localparam logic [CODE_W-1:0] XOVER = 8'hA5;

  function automatic logic [PGA_W-1:0] pga_idx(input logic [CODE_W-1:0] c);
    return (c >= XOVER) ? PGA_W'(c - XOVER) : '0;
  endfunction

  function automatic logic [CODE_W-1:0] att_steps(input logic [CODE_W-1:0] c);
    return (c >= XOVER) ? '0 : CODE_W'(XOVER - c);
  endfunction
endpackage

// File: rtl/ags_zc_track.sv
module ags_zc_track
  import adc_gain_pkg::*;
#(
  parameter int TIMEOUT = 4096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  input  logic              zc_en_i,
  input  logic              valid_i,
  input  logic              sign_i,
  output logic [CODE_W-1:0] act_code_o,
  output logic              apply_o
);
  localparam int CW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;

  logic          prev_sign;
  logic [CW-1:0] cnt;
  logic          pending, zc_hit, tmo;

  assign pending = (code_i != act_code_o);
  assign zc_hit  = valid_i && (sign_i != prev_sign);
  assign tmo     = valid_i && (cnt == CW'(TIMEOUT - 1));
  assign apply_o = pending && (!zc_en_i || zc_hit || tmo);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_code_o <= '0;
      prev_sign  <= 1'b0;
      cnt        <= '0;
    end else begin
      if (apply_o) act_code_o <= code_i;
      if (valid_i) prev_sign <= sign_i;
      if (!pending || apply_o || !zc_en_i) cnt <= '0;
      else if (valid_i)                     cnt <= cnt + 1'b1;
    end
  end

  AST_NOZC_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !zc_en_i |=> act_code_o == $past(code_i)); // R4
  AST_ZC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zc_en_i && !valid_i |=> $stable(act_code_o)); // R5
endmodule

// File: rtl/ags_atten.sv
module ags_atten
  import adc_gain_pkg::*;
#(
  parameter int SW = 24
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [CODE_W-1:0]    code_i,
  input  logic signed [SW-1:0] sample_i,
  output logic signed [SW-1:0] sample_o
);
  localparam int CF_W = 17;
  localparam int PW   = SW + CF_W + 1;

  logic [CODE_W-1:0]     steps;
  logic [CODE_W-1:0]     oct;
  logic [3:0]            frac;
  logic [CF_W-1:0]       coef;
  logic signed [PW-1:0]  prod;
  logic signed [PW-1:0]  shifted;

  assign steps = att_steps(code_i);
  assign oct   = steps / 8'd12;
  assign frac  = 4'(steps % 8'd12);

  // 0.5 dB step coefficients, 1.0 = 65536
  always_comb begin
    unique case (frac)
      4'd0:    coef = 17'd65536;
      4'd1:    coef = 17'd61870;
      4'd2:    coef = 17'd58409;
      4'd3:    coef = 17'd55142;
      4'd4:    coef = 17'd52057;
      4'd5:    coef = 17'd49145;
      4'd6:    coef = 17'd46396;
      4'd7:    coef = 17'd43801;
      4'd8:    coef = 17'd41350;
      4'd9:    coef = 17'd39037;
      4'd10:   coef = 17'd36854;
      default: coef = 17'd34792;
    endcase
  end

  assign prod    = PW'(sample_i) * $signed({1'b0, coef});
  assign shifted = prod >>> (oct + 8'd16);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sample_o <= '0;
    else if (valid_i) sample_o <= (code_i == '0) ? '0 : shifted[SW-1:0];
  end

  AST_MUTE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && code_i == '0 |=> sample_o == '0); // R3
  AST_SAMPLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(sample_o)); // R9
endmodule

// File: rtl/adc_gain_split.sv
module adc_gain_split
  import adc_gain_pkg::*;
#(
  parameter int NUM_CH  = 2,
  parameter int SW      = 24,
  parameter int TIMEOUT = 4096
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_CH-1:0][CODE_W-1:0]    gain_code_i,
  input  logic [NUM_CH-1:0]                zc_en_i,
  input  logic [NUM_CH-1:0][SW-1:0]        sample_i,
  input  logic                             valid_i,
  output logic [NUM_CH-1:0][PGA_W-1:0]     pga_code_o,
  output logic [NUM_CH-1:0][SW-1:0]        sample_o,
  output logic                             valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= valid_i;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [CODE_W-1:0] act_code, dig_code;
    logic              apply;

    ags_zc_track #(.TIMEOUT(TIMEOUT)) i_track (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .code_i     (gain_code_i[ch]),
      .zc_en_i    (zc_en_i[ch]),
      .valid_i    (valid_i),
      .sign_i     (sample_i[ch][SW-1]),
      .act_code_o (act_code),
      .apply_o    (apply)
    );

    // digital part waits for the amplifier only when the amplifier setting moves
    assign dig_code = (apply || pga_idx(gain_code_i[ch]) == pga_idx(act_code))
                    ? gain_code_i[ch] : act_code;
    assign pga_code_o[ch] = pga_idx(act_code);

    ags_atten #(.SW(SW)) i_atten (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .valid_i  (valid_i),
      .code_i   (dig_code),
      .sample_i (sample_i[ch]),
      .sample_o (sample_o[ch])
    );

    AST_PGA_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pga_code_o[ch] <= PGA_W'(90)); // R1
    AST_PGA_WITH_DIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> $stable(pga_code_o[ch]) || !zc_en_i[ch]); // R7
  end

  AST_VALID_PIPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R9
endmodule

// File: tb/test_adc_gain_split.sv
module test_adc_gain_split;
  localparam int SW = 24;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0][7:0]  code = '0;
  logic [1:0]       zc_en = '0;
  logic [1:0][23:0] samp = '0;
  logic             vld = 1'b0;
  logic [1:0][6:0]  pga;
  logic [1:0][23:0] sout;
  logic             vout;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  adc_gain_split i_adc_gain_split (
    .clk_i(clk), .rst_ni(rst_n), .gain_code_i(code), .zc_en_i(zc_en),
    .sample_i(samp), .valid_i(vld), .pga_code_o(pga), .sample_o(sout), .valid_o(vout)
  );

  typedef struct packed {
    logic [7:0]        code;
    logic signed [23:0] s;
    logic [6:0]        pga;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{8'hFF,  24'sd1000,    7'd90},
    '{8'hCF, -24'sd777,     7'd42},
    '{8'hA5,  24'sd4000000, 7'd0},
    '{8'hA4, -24'sd4000000, 7'd0},
    '{8'h01,  24'sd8388607, 7'd0},
    '{8'h00,  24'sd12345,   7'd0},
    '{8'hA6, -24'sd8388608, 7'd1},
    '{8'h98,  24'sd3000001, 7'd0}
  };

  function automatic logic [6:0] ref_pga(input logic [7:0] c);
    return (c >= 8'hA5) ? 7'(c - 8'hA5) : 7'd0;
  endfunction

  function automatic logic [23:0] ref_out(input logic [7:0] c, input logic [23:0] s);
    int n, q, r;
    longint cf, p;
    if (c == 8'h00) return 24'd0;
    n  = (c >= 8'hA5) ? 0 : int'(8'hA5) - int'(c);
    q  = n / 12;
    r  = n % 12;
    cf = longint'($rtoi(65536.0 * (10.0 ** (-r / 40.0)) + 0.5));
    p  = longint'($signed(s)) * cf;
    return 24'(p >>> (16 + q));
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_out(input int ch, input logic [7:0] c, input logic [23:0] s, input string tag);
    logic [23:0] e;
    e = ref_out(c, s);
    check(sout[ch] == e, tag, longint'($signed(sout[ch])), longint'($signed(e)));
  endtask

  task automatic chk_pga(input int ch, input logic [6:0] e, input string tag);
    check(pga[ch] == e, tag, longint'(pga[ch]), longint'(e));
  endtask

  task automatic chk_reset();
    check(pga == '0, "R10 pga", longint'(pga), 0);
    check(sout == '0, "R10 sample", longint'(sout), 0);
    check(vout == 1'b0, "R10 valid", longint'(vout), 0);
  endtask

  initial begin
    logic [23:0] held;
    repeat (3) @(negedge clk);
    chk_reset();
    rst_n = 1'b1;
    @(negedge clk);

    // table walk, immediate updates on both channels
    for (int i = 0; i < 8; i++) begin
      logic [7:0]  c1;
      logic [23:0] s1;
      c1 = ~VEC[i].code;
      s1 = -VEC[i].s;
      zc_en = 2'b00;
      code  = {c1, VEC[i].code};
      samp  = {s1, VEC[i].s};
      vld   = 1'b1;
      tick();
      chk_pga(0, VEC[i].pga, "R1 R4 pga ch0");
      chk_pga(1, ref_pga(c1), "R1 R11 pga ch1");
      chk_out(0, VEC[i].code, VEC[i].s, (VEC[i].code == 0) ? "R3 mute ch0" : "R2 atten ch0");
      chk_out(1, c1, s1, "R2 R11 atten ch1");
      check(vout, "R9 valid_o", longint'(vout), 1);
    end

    // no strobe: output holds
    held = sout[0];
    vld  = 1'b0;
    samp[0] = 24'sd55;
    tick();
    check(vout == 1'b0, "R9 valid_o low", longint'(vout), 0);
    check(sout[0] == held, "R9 sample hold", longint'(sout[0]), longint'(held));

    // zero-cross wait across the crossover
    zc_en = 2'b00; code[0] = 8'hFF; code[1] = 8'hB0;
    samp[0] = 24'sd100; samp[1] = 24'sd100; vld = 1'b1;
    tick();
    chk_pga(0, 7'd90, "R4 setup");
    zc_en[0] = 1'b1; code[0] = 8'h50;
    samp[0] = 24'sd2000;
    tick();
    chk_pga(0, 7'd90, "R5 held");
    chk_out(0, 8'hFF, 24'sd2000, "R7 old digital");
    samp[0] = 24'sd3000;
    tick();
    chk_pga(0, 7'd90, "R5 still held");
    samp[0] = -24'sd4000;
    tick();
    chk_pga(0, 7'd0, "R5 commit on crossing");
    chk_out(0, 8'h50, -24'sd4000, "R7 new digital same sample");
    chk_pga(1, 7'd11, "R11 ch1 unaffected");

    // same amplifier setting: digital immediate
    code[0] = 8'h80; samp[0] = -24'sd500;
    tick();
    chk_out(0, 8'h80, -24'sd500, "R8 immediate digital");
    chk_pga(0, 7'd0, "R8 pga");
    samp[0] = 24'sd500;
    tick();
    chk_out(0, 8'h80, 24'sd500, "R8 after crossing");

    // timeout with no crossing
    code[0] = 8'hC0; samp[0] = 24'sd7000;
    for (int k = 0; k < 4095; k++) tick();
    chk_pga(0, 7'd0, "R6 before timeout");
    chk_out(0, 8'h80, 24'sd7000, "R7 old digital while waiting");
    tick();
    chk_pga(0, 7'd27, "R6 commit at timeout");
    chk_out(0, 8'hC0, 24'sd7000, "R7 digital at timeout");

    // reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    chk_reset();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule